// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces column addresses for a synchronous DRAM burst, one per clock. A start strobe loads a start column, a burst length code, a burst ordering (sequential or interleaved) and the direction of the access. From the next clock edge the sequencer walks through the beat addresses, flags the final beat and reports that a burst is in progress. A full-page burst keeps running until a stop input ends it.

A controller drives the strobe when it issues a read or write column command. It drives the stop input for a burst-terminate or precharge. A separate mode input can force every write to a single beat while reads keep the programmed length. All outputs come from registers loaded at the clock edge.

Top module: `sdram_burst_colseq`

## Requirements
- R1: While `rst` is high, and on the edge where it is sampled, `busy_o` and `last_o` go to 0 and `col_o` goes to 0.
- R2: When `start_i` is high at a clock edge, after that edge `busy_o` is 1 and `col_o` equals the sampled `col_i`. This is beat 0.
- R3: The `blen_i` encoding gives the number of beats: 0 is 1 beat, 1 is 2, 2 is 4, 3 is 8 and 7 is full page. Codes 4, 5 and 6 are treated as 1 beat.
- R4: With `ilv_i` = 0 (sequential), beat k is `col_i` + k inside the block of BL columns aligned to BL. The low log2(BL) bits wrap and the upper bits stay fixed.
- R5: With `ilv_i` = 1 (interleaved), for a fixed length, beat k is `col_i` XOR k, where k only touches the low log2(BL) bits.
- R6: A full-page burst always uses sequential order, and `ilv_i` is ignored for it. It steps through all 8 column bits, wrapping from 255 to 0, and continues until stopped.
- R7: `last_o` is 1 exactly on the final beat of a fixed-length burst and is never 1 during a full-page burst. `busy_o` falls at the edge after the final beat unless a new start is sampled there.
- R8: `stop_i` high at an edge while busy, and without `start_i`, makes `busy_o` and `last_o` 0 after that edge.
- R9: When `is_write_i` = 1 and `wr_single_i` = 1 at the start, the burst is a single beat whatever `blen_i` is. With `is_write_i` = 0, `wr_single_i` has no effect.
- R10: A `start_i` sampled during an active burst restarts the sequence at the new column at that edge. `start_i` wins over a simultaneous `stop_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a burst with the values below |
| col_i | input | 8 | Start column |
| blen_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 selects interleaved order, 0 sequential |
| is_write_i | input | 1 | The burst is a write |
| wr_single_i | input | 1 | Force writes to one beat |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | 8 | Column address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is in progress |

## Verification
The assertions check several rules on every cycle. A start loads beat 0 with the sampled column. A stop, or a final beat, drops busy at the next edge. A write forced to one beat is flagged as last immediately. A full-page burst never raises the last flag. The beat counter steps by one and keeps its base between start and end.

Only the bench scenarios can show the exact address orderings: sequential wrap inside the aligned block, the XOR pattern, and the 255-to-0 wrap of a full page. The same applies to the beat count for each length code, the reserved codes, and a restart in the middle of a burst.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    localparam int BLEN_W = 3;
    localparam int LG_W   = 4;

    localparam logic [BLEN_W-1:0] BLC_ONE  = 3'd0;
    localparam logic [BLEN_W-1:0] BLC_TWO  = 3'd1;
    localparam logic [BLEN_W-1:0] BLC_FOUR = 3'd2;
    localparam logic [BLEN_W-1:0] BLC_EGHT = 3'd3;
    localparam logic [BLEN_W-1:0] BLC_PAGE = 3'd7;

    typedef enum logic {ORD_SEQ = 1'b0, ORD_XOR = 1'b1} order_e;

    typedef struct packed {
        logic            full;
        order_e          order;
        logic [LG_W-1:0] lg;
    } burst_cfg_t;

    function automatic burst_cfg_t decode_cfg(
        input logic [BLEN_W-1:0] code,
        input logic              ilv,
        input logic              wr,
        input logic              wr_single
    );
        burst_cfg_t c;
        c.full  = 1'b0;
        c.order = ilv ? ORD_XOR : ORD_SEQ;
        case (code)
            BLC_TWO:  c.lg = 4'd1;
            BLC_FOUR: c.lg = 4'd2;
            BLC_EGHT: c.lg = 4'd3;
            BLC_PAGE: begin
                c.lg    = 4'd0;
                c.full  = 1'b1;
                c.order = ORD_SEQ;
            end
            default:  c.lg = 4'd0;
        endcase
        if (wr && wr_single) begin
            c.full  = 1'b0;
            c.lg    = 4'd0;
        end
        return c;
    endfunction

endpackage

// File: rtl/colseq_mode_dec.sv
module colseq_mode_dec
    import colseq_pkg::*;
(
    input  logic [BLEN_W-1:0] blen_i,
    input  logic              ilv_i,
    input  logic              is_write_i,
    input  logic              wr_single_i,
    output burst_cfg_t        cfg_o
);

    always_comb begin
        cfg_o = decode_cfg(blen_i, ilv_i, is_write_i, wr_single_i);
    end

endmodule

// File: rtl/colseq_beat_ctr.sv
module colseq_beat_ctr
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] col_i,
    input  burst_cfg_t       cfg_i,
    output logic             busy_o,
    output logic             end_beat_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output burst_cfg_t       cfg_o
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic             busy_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] base_q;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] mask;
    logic             end_beat;

    always_comb begin
        mask     = cfg_q.full ? {COL_W{1'b1}} : ((ONE << cfg_q.lg) - ONE);
        end_beat = !cfg_q.full && (cnt_q == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            base_q <= '0;
            cfg_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            base_q <= col_i;
            cfg_q  <= cfg_i;
        end else if (busy_q) begin
            if (stop_i || end_beat) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q  <= cnt_q + ONE;
            end
        end
    end

    assign busy_o     = busy_q;
    assign end_beat_o = end_beat;
    assign cnt_o      = cnt_q;
    assign base_o     = base_q;
    assign mask_o     = mask;
    assign cfg_o      = cfg_q;

    // Mid-burst beats advance by one and keep the captured base (R4, R6)
    assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !start_i && !stop_i && !end_beat)
        |=> (cnt_q == $past(cnt_q) + ONE) && (base_q == $past(base_q)));

endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;

    always_comb begin
        sum = base_i + cnt_i;
    end

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign seq_col[b] = mask_i[b] ? sum[b] : base_i[b];
        assign xor_col[b] = base_i[b] ^ (cnt_i[b] & mask_i[b]);
    end

    assign col_o = (order_i == ORD_XOR) ? xor_col : seq_col;

endmodule

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [BLEN_W-1:0] blen_i,
    input  logic              ilv_i,
    input  logic              is_write_i,
    input  logic              wr_single_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              last_o,
    output logic              busy_o
);

    burst_cfg_t       cfg_new;
    burst_cfg_t       cfg_cur;
    logic             busy;
    logic             end_beat;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] mask;

    colseq_mode_dec u_dec (
        .blen_i      (blen_i),
        .ilv_i       (ilv_i),
        .is_write_i  (is_write_i),
        .wr_single_i (wr_single_i),
        .cfg_o       (cfg_new)
    );

    colseq_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .col_i      (col_i),
        .cfg_i      (cfg_new),
        .busy_o     (busy),
        .end_beat_o (end_beat),
        .cnt_o      (cnt),
        .base_o     (base),
        .mask_o     (mask),
        .cfg_o      (cfg_cur)
    );

    colseq_addr_gen #(.COL_W(COL_W)) u_addr (
        .base_i  (base),
        .cnt_i   (cnt),
        .mask_i  (mask),
        .order_i (cfg_cur.order),
        .col_o   (col_o)
    );

    assign busy_o = busy;
    assign last_o = busy && end_beat;

    // Start loads beat 0 with the sampled column, also mid-burst (R2, R10)
    assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_o && (col_o == $past(col_i)));

    // Final beat ends the burst unless restarted (R7)
    assert_last_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !busy_o);

    // Stop without start terminates (R8)
    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && stop_i && !start_i) |=> (!busy_o && !last_o));

    // Write forced to one beat is last at once (R9)
    assert_wr_single_R9: assert property (@(posedge clk) disable iff (rst)
        (start_i && is_write_i && wr_single_i) |=> last_o);

    // Full page never flags a last beat (R6)
    assert_page_nolast_R6: assert property (@(posedge clk) disable iff (rst)
        (start_i && blen_i == BLC_PAGE && !(is_write_i && wr_single_i))
        |=> !last_o);

endmodule

// File: tb/sdram_burst_colseq_tb_top.sv
module sdram_burst_colseq_tb_top;

    typedef struct packed {
        logic [7:0] col;
        logic [2:0] code;
        logic       ilv;
        logic       wr;
        logic       ws;
        logic [8:0] beats;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h05, 3'd0, 1'b0, 1'b0, 1'b0, 9'd1},
        '{8'h05, 3'd1, 1'b0, 1'b0, 1'b0, 9'd2},
        '{8'h06, 3'd2, 1'b0, 1'b0, 1'b0, 9'd4},
        '{8'h05, 3'd2, 1'b1, 1'b0, 1'b0, 9'd4},
        '{8'h2D, 3'd3, 1'b0, 1'b0, 1'b0, 9'd8},
        '{8'h2D, 3'd3, 1'b1, 1'b0, 1'b0, 9'd8},
        '{8'h13, 3'd3, 1'b0, 1'b1, 1'b1, 9'd1},
        '{8'h13, 3'd3, 1'b0, 1'b0, 1'b1, 9'd8},
        '{8'h13, 3'd2, 1'b1, 1'b1, 1'b0, 9'd4},
        '{8'hFE, 3'd5, 1'b0, 1'b0, 1'b0, 9'd1},
        '{8'hFF, 3'd3, 1'b0, 1'b1, 1'b0, 9'd8},
        '{8'hC3, 3'd4, 1'b1, 1'b0, 1'b0, 9'd1}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i, ilv_i, is_write_i, wr_single_i, stop_i;
    logic [7:0] col_i;
    logic [2:0] blen_i;
    logic [7:0] col_o;
    logic       last_o, busy_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdram_burst_colseq dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .col_i(col_i),
        .blen_i(blen_i), .ilv_i(ilv_i), .is_write_i(is_write_i),
        .wr_single_i(wr_single_i), .stop_i(stop_i),
        .col_o(col_o), .last_o(last_o), .busy_o(busy_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_col(input int st, input int len, input bit ilv, input int k);
        if (ilv) return st ^ k;
        return (st - (st % len)) + (((st % len) + k) % len);
    endfunction

    task automatic launch(input logic [7:0] c, input logic [2:0] code,
                          input logic ilv, input logic wr, input logic ws);
        start_i = 1'b1; col_i = c; blen_i = code;
        ilv_i = ilv; is_write_i = wr; wr_single_i = ws;
        @(negedge clk);
        start_i = 1'b0; ilv_i = ~ilv; wr_single_i = ~ws; blen_i = 3'd7;
    endtask

    task automatic run_vec(input vec_t v);
        int len;
        len = int'(v.beats);
        launch(v.col, v.code, v.ilv, v.wr, v.ws);
        for (int k = 0; k < len; k++) begin
            chk("R2/R3/R4/R5/R9 col", col_o, exp_col(v.col, len, v.ilv, k));
            chk("R3/R7 last", last_o, (k == len - 1) ? 1 : 0);
            chk("R3 busy", busy_o, 1);
            @(negedge clk);
        end
        chk("R7 busy drops after last beat", busy_o, 0);
        chk("R7 last clear when idle", last_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; stop_i = 1'b0; col_i = 8'h00;
        blen_i = 3'd0; ilv_i = 1'b0; is_write_i = 1'b0; wr_single_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 last", last_o, 0);
        chk("R1 col", col_o, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6: full page, ilv requested but ignored, wraps 255 -> 0
        launch(8'hFA, 3'd7, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 260; k++) begin
            chk("R6 page col", col_o, (8'hFA + k) % 256);
            chk("R6 page never last", last_o, 0);
            chk("R6 page busy", busy_o, 1);
            @(negedge clk);
        end
        // R8: stop ends full page
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 stop page busy", busy_o, 0);

        // R8: stop a fixed burst after beat 0
        launch(8'h80, 3'd3, 1'b0, 1'b0, 1'b0);
        chk("R2 beat0", col_o, 8'h80);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 stop fixed busy", busy_o, 0);
        chk("R8 stop fixed last", last_o, 0);

        // R10: restart mid-burst with stop asserted at the same edge
        launch(8'h10, 3'd3, 1'b0, 1'b0, 1'b0);
        chk("R10 first burst beat0", col_o, 8'h10);
        @(negedge clk);
        chk("R10 first burst beat1", col_o, 8'h11);
        stop_i = 1'b1;
        launch(8'h45, 3'd2, 1'b1, 1'b0, 1'b0);
        stop_i = 1'b0;
        chk("R10 restart busy", busy_o, 1);
        for (int k = 0; k < 4; k++) begin
            chk("R10 restart col", col_o, 8'h45 ^ k);
            chk("R10 restart last", last_o, (k == 3) ? 1 : 0);
            @(negedge clk);
        end
        chk("R10 restart done", busy_o, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule